// File: doc/BRIEF.md
# Multidrop UART with Address Wake-Up

This block is a serial transceiver for a shared bus with one master and several slaves. In multidrop mode, each frame carries one extra bit after the eight data bits. This bit tags the frame as an address (ID) frame when it is 1, or as a data frame when it is 0. A master selects a slave by sending an address frame. Each slave keeps its receive wake-up control set while it waits. In that state it passes on only address frames and raises its receive interrupt for them. Software compares the ID. The selected slave clears its wake-up control and from then on takes data frames. Slaves that were not selected keep the control set and drop the data traffic without any sign.

Bit timing comes from a divisor input with 16x oversampling. A shared tick generator drives both directions. The transmitter state machine walks through TX_IDLE, TX_START, TX_DATA, TX_WAKE and TX_STOP:
- IDLE to START happens on a start request.
- START to DATA happens after one bit time.
- DATA to WAKE happens after the eighth data bit in multidrop mode, and DATA to STOP happens after it otherwise.
- WAKE to STOP happens after one bit time.
- STOP to IDLE happens after one bit time.

The receiver state machine walks through RX_IDLE, RX_START, RX_DATA, RX_WAKE and RX_STOP:
- IDLE to START happens on a low line at a tick.
- At mid start bit, START goes to DATA if the line is still low, or back to IDLE if it is high.
- DATA to WAKE or DATA to STOP happens after the eighth sample, in the same way as the transmitter.
- WAKE to STOP happens after the wake-up bit is sampled.
- STOP to IDLE happens at the stop-bit sample, and the frame is handed off at that point.

An open-drain option turns the transmit pin into a pull-low output enable, so several slaves can share one return line.

Top module: `mdrop_uart`

## Requirements
- R1: The mode field `cfg_mode` selects the frame format. A value of 2'b10 or 2'b11 gives 11-bit frames: start (0), eight data bits, wake-up bit, stop (1). Any other value gives 10-bit frames with no wake-up bit. `tx_busy` rises together with the start bit and falls within one bit time after the stop bit's middle.
- R2: In multidrop mode, a transmitted frame's wake-up bit equals `cfg_tx_wake` as sampled at the start request.
- R3: For an accepted frame, `rx_wake` reports its received wake-up bit: 1 means an address frame and 0 means a data frame. Frames in normal format report 0.
- R4: In multidrop mode with `cfg_rx_wake` set, a data frame leaves `rx_valid` and `rx_irq` unchanged. An address frame sets `rx_valid`, sets `rx_irq` and sets `rx_wake` to 1.
- R5: With `cfg_rx_wake` clear, multidrop data frames are accepted with `rx_wake` 0.
- R6: With `cfg_od_en` set, `txd_o` is always 0 and `txd_oe` is 1 exactly while the line must be low. With `cfg_od_en` clear, `txd_oe` is 1 and `txd_o` carries the line.
- R7: If the stop bit is sampled low, the frame is still delivered and `rx_frame_err` is 1. If the stop bit is high, `rx_frame_err` is 0.
- R8: A low pulse on `rxd` that is shorter than half a bit is rejected as a glitch, and no frame is delivered.
- R9: When an accepted frame arrives while `rx_valid` is still set, `rx_overrun` is set and the new byte replaces the old one. A pulse on `rx_read` clears both `rx_valid` and `rx_overrun`.
- R10: After reset, the line is idle high, `tx_busy` is 0 and `rx_valid` is 0.
- R11: Data bits go LSB first. Each bit after the start bit lasts 16 times `divisor` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| divisor | input | DIV_W | Clock cycles per oversampling tick |
| cfg_mode | input | 2 | Frame format select; 2'b10/2'b11 selects multidrop |
| cfg_tx_wake | input | 1 | Wake-up bit value for transmitted frames |
| cfg_rx_wake | input | 1 | Receive wake-up control: drop data frames while set |
| cfg_od_en | input | 1 | Open-drain transmit enable |
| tx_data | input | DATA_W | Byte to transmit |
| tx_start | input | 1 | Start request, taken only when idle |
| tx_busy | output | 1 | Transmitter frame in progress |
| txd_o | output | 1 | Transmit pad data value |
| txd_oe | output | 1 | Transmit pad output enable |
| rxd | input | 1 | Serial receive line |
| rx_data | output | DATA_W | Last accepted byte |
| rx_wake | output | 1 | Wake-up bit of the last accepted frame |
| rx_frame_err | output | 1 | Stop bit of the last accepted frame was low |
| rx_overrun | output | 1 | An accepted frame overwrote an unread one |
| rx_valid | output | 1 | Unread accepted frame held |
| rx_irq | output | 1 | Receive interrupt request |
| rx_read | input | 1 | Acknowledges the held frame |

## Verification
If the transmitter takes a wrong state branch, the serial line shows it within one bit time. A missing or extra wake-up bit shifts the stop-bit position, so the sample at bit ten reads the wrong level. A shift register out of step corrupts the LSB-first order at the first data-bit sample. On the receive side, a wrong filter decision or a wrong glitch decision appears as a wrong `rx_valid` level one bit time after the frame's stop bit. A wrong overrun state appears on the very next accepted frame or on the next read.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_WAKE,
        TX_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_WAKE,
        RX_STOP
    } rx_state_t;

    // Multidrop framing is selected by the two upper codes of the mode field.
    function automatic logic is_multidrop(input logic [1:0] mode);
        return mode inside {2'b10, 2'b11};
    endfunction

endpackage

// File: rtl/mdu_baud.sv
module mdu_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    // A divisor of 0 behaves like 1: a tick every cycle.
    assign tick = ({1'b0, cnt_q} + 1'b1) >= {1'b0, divisor};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/mdu_tx.sv
module mdu_tx
    import mdu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    input  logic              mc,
    input  logic              wake,
    output logic              busy,
    output logic              line
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    tx_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] sh_q, sh_d;
    logic              mc_q, wk_q, line_q;
    logic              bit_end, last_bit;

    assign bit_end  = tick && (cnt_q == CNT_W'(OVS - 1));
    assign last_bit = (idx_q == IDX_W'(DATA_W - 1));

    // Next-state and shift-register update
    always_comb begin
        state_d = state_q;
        sh_d    = sh_q;
        unique case (state_q)
            TX_IDLE: begin
                if (start) begin
                    state_d = TX_START;
                    sh_d    = data;
                end
            end
            TX_START: begin
                if (bit_end) state_d = TX_DATA;
            end
            TX_DATA: begin
                if (bit_end) begin
                    sh_d = sh_q >> 1;
                    if (last_bit) state_d = mc_q ? TX_WAKE : TX_STOP;
                end
            end
            TX_WAKE: begin
                if (bit_end) state_d = TX_STOP;
            end
            TX_STOP: begin
                if (bit_end) state_d = TX_IDLE;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and registered line output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            sh_q   <= '0;
            mc_q   <= 1'b0;
            wk_q   <= 1'b0;
            line_q <= 1'b1;
        end else begin
            sh_q <= sh_d;
            if (state_d != state_q || bit_end) cnt_q <= '0;
            else if (tick)                     cnt_q <= cnt_q + 1'b1;
            if (state_q == TX_START)                idx_q <= '0;
            else if (state_q == TX_DATA && bit_end) idx_q <= idx_q + 1'b1;
            if (state_q == TX_IDLE && start) begin
                mc_q <= mc;
                wk_q <= wake;
            end
            unique case (state_d)
                TX_START: line_q <= 1'b0;
                TX_DATA:  line_q <= sh_d[0];
                TX_WAKE:  line_q <= wk_q;
                default:  line_q <= 1'b1;
            endcase
        end
    end

    assign busy = (state_q != TX_IDLE);
    assign line = line_q;
endmodule

// File: rtl/mdu_rx.sv
module mdu_rx
    import mdu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              mc,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              wake,
    output logic              frame_mc,
    output logic              ferr
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int HALF  = OVS / 2;

    rx_state_t         state_q, state_d;
    logic [1:0]        sync_q;
    logic              rx_s;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] sh_q;
    logic              mc_q, wk_q, done_q, ferr_q;
    logic              samp, mid_start, last_bit;

    assign rx_s      = sync_q[1];
    assign samp      = tick && (cnt_q == CNT_W'(OVS - 1));
    assign mid_start = tick && (cnt_q == CNT_W'(HALF - 1));
    assign last_bit  = (idx_q == IDX_W'(DATA_W - 1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (tick && !rx_s) state_d = RX_START;
            end
            RX_START: begin
                if (mid_start) state_d = rx_s ? RX_IDLE : RX_DATA;
            end
            RX_DATA: begin
                if (samp && last_bit) state_d = mc_q ? RX_WAKE : RX_STOP;
            end
            RX_WAKE: begin
                if (samp) state_d = RX_STOP;
            end
            RX_STOP: begin
                if (samp) state_d = RX_IDLE;
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // Synchronizer, sampling datapath and frame hand-off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            idx_q  <= '0;
            sh_q   <= '0;
            mc_q   <= 1'b0;
            wk_q   <= 1'b0;
            done_q <= 1'b0;
            ferr_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], rxd};
            if (state_q == RX_IDLE || state_d != state_q || samp) cnt_q <= '0;
            else if (tick)                                         cnt_q <= cnt_q + 1'b1;
            if (state_q == RX_IDLE && state_d == RX_START) mc_q <= mc;
            if (state_q == RX_START) begin
                idx_q <= '0;
                wk_q  <= 1'b0;
            end
            if (state_q == RX_DATA && samp) begin
                sh_q  <= {rx_s, sh_q[DATA_W-1:1]};
                idx_q <= idx_q + 1'b1;
            end
            if (state_q == RX_WAKE && samp) wk_q <= rx_s;
            done_q <= (state_q == RX_STOP) && samp;
            if (state_q == RX_STOP && samp) ferr_q <= !rx_s;
        end
    end

    assign done     = done_q;
    assign data     = sh_q;
    assign wake     = wk_q;
    assign frame_mc = mc_q;
    assign ferr     = ferr_q;
endmodule

// File: rtl/mdrop_uart.sv
module mdrop_uart
    import mdu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_tx_wake,
    input  logic              cfg_rx_wake,
    input  logic              cfg_od_en,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_start,
    output logic              tx_busy,
    output logic              txd_o,
    output logic              txd_oe,
    input  logic              rxd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_wake,
    output logic              rx_frame_err,
    output logic              rx_overrun,
    output logic              rx_valid,
    output logic              rx_irq,
    input  logic              rx_read
);
    logic              tick;
    logic              mc;
    logic              tx_line;
    logic              f_done, f_wake, f_mc, f_ferr;
    logic [DATA_W-1:0] f_data;
    logic              accept;

    logic [DATA_W-1:0] hold_data_q;
    logic              hold_wake_q, hold_ferr_q, valid_q, ovr_q;

    assign mc = is_multidrop(cfg_mode);

    mdu_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .tick    (tick)
    );

    mdu_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .start (tx_start),
        .data  (tx_data),
        .mc    (mc),
        .wake  (cfg_tx_wake),
        .busy  (tx_busy),
        .line  (tx_line)
    );

    mdu_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .rxd      (rxd),
        .mc       (mc),
        .done     (f_done),
        .data     (f_data),
        .wake     (f_wake),
        .frame_mc (f_mc),
        .ferr     (f_ferr)
    );

    // Address filter: while waiting for wake-up, drop multidrop data frames.
    assign accept = f_done && !(f_mc && cfg_rx_wake && !f_wake);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data_q <= '0;
            hold_wake_q <= 1'b0;
            hold_ferr_q <= 1'b0;
            valid_q     <= 1'b0;
            ovr_q       <= 1'b0;
        end else if (accept) begin
            hold_data_q <= f_data;
            hold_wake_q <= f_wake;
            hold_ferr_q <= f_ferr;
            valid_q     <= 1'b1;
            ovr_q       <= valid_q && !rx_read;
        end else if (rx_read) begin
            valid_q <= 1'b0;
            ovr_q   <= 1'b0;
        end
    end

    // Open drain: pad data tied low, enable pulls the line down.
    always_comb begin
        if (cfg_od_en) begin
            txd_o  = 1'b0;
            txd_oe = !tx_line;
        end else begin
            txd_o  = tx_line;
            txd_oe = 1'b1;
        end
    end

    assign rx_data      = hold_data_q;
    assign rx_wake      = hold_wake_q;
    assign rx_frame_err = hold_ferr_q;
    assign rx_overrun   = ovr_q;
    assign rx_valid     = valid_q;
    assign rx_irq       = valid_q;
endmodule

// File: rtl/mdrop_uart_chk.sv
module mdrop_uart_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_mode,
    input logic       cfg_rx_wake,
    input logic       cfg_od_en,
    input logic       tx_busy,
    input logic       tx_line,
    input logic       txd_o,
    input logic       txd_oe,
    input logic       rx_wake,
    input logic       rx_valid,
    input logic       rx_overrun,
    input logic       rx_read
);
    // R1
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !tx_line);

    // R10
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> (cfg_od_en ? (!txd_oe && !txd_o) : (txd_oe && txd_o)));

    // R4
    wake_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_valid) && $past(cfg_rx_wake) && ($past(cfg_mode) inside {2'b10, 2'b11}))
        |-> rx_wake);

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_read |=> !rx_overrun);

    // R9
    overrun_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> rx_valid);
endmodule

bind mdrop_uart mdrop_uart_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_mode    (cfg_mode),
    .cfg_rx_wake (cfg_rx_wake),
    .cfg_od_en   (cfg_od_en),
    .tx_busy     (tx_busy),
    .tx_line     (tx_line),
    .txd_o       (txd_o),
    .txd_oe      (txd_oe),
    .rx_wake     (rx_wake),
    .rx_valid    (rx_valid),
    .rx_overrun  (rx_overrun),
    .rx_read     (rx_read)
);

// File: tb/mdrop_uart_tb.sv
module mdrop_uart_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] divisor;
    logic [1:0]  cfg_mode;
    logic        cfg_tx_wake, cfg_rx_wake, cfg_od_en;
    logic [7:0]  tx_data;
    logic        tx_start;
    logic        tx_busy, txd_o, txd_oe;
    logic        rxd;
    logic [7:0]  rx_data;
    logic        rx_wake, rx_frame_err, rx_overrun, rx_valid, rx_irq;
    logic        rx_read;
    logic        line_eff;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    assign line_eff = cfg_od_en ? !txd_oe : txd_o;

    mdrop_uart u_dut (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .cfg_mode(cfg_mode),
        .cfg_tx_wake(cfg_tx_wake), .cfg_rx_wake(cfg_rx_wake), .cfg_od_en(cfg_od_en),
        .tx_data(tx_data), .tx_start(tx_start), .tx_busy(tx_busy),
        .txd_o(txd_o), .txd_oe(txd_oe), .rxd(rxd), .rx_data(rx_data),
        .rx_wake(rx_wake), .rx_frame_err(rx_frame_err), .rx_overrun(rx_overrun),
        .rx_valid(rx_valid), .rx_irq(rx_irq), .rx_read(rx_read)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic do_read();
        @(negedge clk) rx_read = 1'b1;
        @(negedge clk) rx_read = 1'b0;
    endtask

    // Serial frame into rxd, then one idle bit
    task automatic send_rx(input logic [7:0] d, input bit has_w, input bit wbit,
                           input bit stop, input int div);
        @(negedge clk) rxd = 1'b0;
        repeat (16 * div) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (16 * div) @(negedge clk);
        end
        if (has_w) begin
            rxd = wbit;
            repeat (16 * div) @(negedge clk);
        end
        rxd = stop;
        repeat (16 * div) @(negedge clk);
        rxd = 1'b1;
        repeat (16 * div) @(negedge clk);
    endtask

    // Launch a frame and sample the line at every bit's middle
    task automatic tx_expect(input logic [7:0] d, input bit has_w, input bit wbit, input int div);
        int w = 0;
        @(negedge clk);
        tx_data  = d;
        tx_start = 1'b1;
        @(negedge clk) tx_start = 1'b0;
        while (line_eff && w < 200) begin
            @(negedge clk);
            w++;
        end
        repeat (8 * div - 1) @(negedge clk);
        chk(line_eff == 1'b0, "R1 start bit", line_eff, 0);
        chk(tx_busy == 1'b1, "R1 busy during frame", tx_busy, 1);
        for (int i = 0; i < 8; i++) begin
            repeat (16 * div) @(negedge clk);
            chk(line_eff == d[i], "R11 data bit LSB first", line_eff, d[i]);
            if (cfg_od_en) chk(txd_o == 1'b0, "R6 pad data low", txd_o, 0);
        end
        if (has_w) begin
            repeat (16 * div) @(negedge clk);
            chk(line_eff == wbit, "R2 wake bit", line_eff, wbit);
        end
        repeat (16 * div) @(negedge clk);
        chk(line_eff == 1'b1, "R1 stop bit", line_eff, 1);
        repeat (8 * div + 2) @(negedge clk);
        chk(tx_busy == 1'b0, "R1 frame end", tx_busy, 0);
    endtask

    task automatic t_reset();
        chk(txd_o == 1'b1 && txd_oe == 1'b1, "R10 idle line", {txd_o, txd_oe}, 3);
        chk(tx_busy == 1'b0, "R10 tx idle", tx_busy, 0);
        chk(rx_valid == 1'b0 && rx_irq == 1'b0, "R10 rx empty", {rx_valid, rx_irq}, 0);
    endtask

    task automatic t_tx_formats();
        cfg_mode = 2'b00; tx_expect(8'hA5, 1'b0, 1'b0, 1);
        cfg_mode = 2'b10; cfg_tx_wake = 1'b1; tx_expect(8'h3C, 1'b1, 1'b1, 1);
        cfg_mode = 2'b11; cfg_tx_wake = 1'b0; tx_expect(8'hC3, 1'b1, 1'b0, 1);
        cfg_mode = 2'b01; tx_expect(8'h96, 1'b0, 1'b0, 1);
    endtask

    task automatic t_tx_div2();
        divisor = 16'd2; cfg_mode = 2'b00;
        tx_expect(8'h5A, 1'b0, 1'b0, 2);   // R11 bit period scales with divisor
        divisor = 16'd1;
    endtask

    task automatic t_tx_od();
        cfg_od_en = 1'b1; cfg_mode = 2'b11; cfg_tx_wake = 1'b1;
        @(negedge clk);
        chk(txd_oe == 1'b0 && txd_o == 1'b0, "R6 released when idle", {txd_o, txd_oe}, 0);
        tx_expect(8'h81, 1'b1, 1'b1, 1);
        cfg_od_en = 1'b0; cfg_tx_wake = 1'b0;
    endtask

    task automatic t_rx_normal();
        cfg_mode = 2'b00;
        send_rx(8'h96, 1'b0, 1'b0, 1'b1, 1);
        chk(rx_valid && rx_irq, "R3 normal frame delivered", {rx_valid, rx_irq}, 3);
        chk(rx_data == 8'h96, "R11 rx data", rx_data, 8'h96);
        chk(rx_wake == 1'b0 && rx_frame_err == 1'b0, "R3 normal wake 0", {rx_wake, rx_frame_err}, 0);
        do_read();
        chk(rx_valid == 1'b0, "R9 read clears valid", rx_valid, 0);
    endtask

    task automatic t_rx_mc();
        cfg_mode = 2'b10; cfg_rx_wake = 1'b0;
        send_rx(8'h11, 1'b1, 1'b0, 1'b1, 1);
        chk(rx_valid && rx_data == 8'h11 && !rx_wake, "R5 data frame accepted",
            {rx_valid, rx_wake, rx_data}, {2'b10, 8'h11});
        do_read();
        send_rx(8'h22, 1'b1, 1'b1, 1'b1, 1);
        chk(rx_valid && rx_wake && rx_data == 8'h22, "R3 address frame wake 1",
            {rx_valid, rx_wake, rx_data}, {2'b11, 8'h22});
        do_read();
    endtask

    task automatic t_rx_filter();
        cfg_mode = 2'b11; cfg_rx_wake = 1'b1;
        send_rx(8'h33, 1'b1, 1'b0, 1'b1, 1);
        chk(!rx_valid && !rx_irq, "R4 data frame dropped", {rx_valid, rx_irq}, 0);
        send_rx(8'h44, 1'b1, 1'b1, 1'b1, 1);
        chk(rx_valid && rx_irq && rx_wake && rx_data == 8'h44, "R4 address frame irq",
            {rx_irq, rx_wake, rx_data}, {2'b11, 8'h44});
        do_read();
        cfg_rx_wake = 1'b0;
        send_rx(8'h55, 1'b1, 1'b0, 1'b1, 1);
        chk(rx_valid && !rx_wake && rx_data == 8'h55, "R5 data after wake clear",
            {rx_valid, rx_wake, rx_data}, {2'b10, 8'h55});
        do_read();
    endtask

    task automatic t_ferr();
        cfg_mode = 2'b00;
        send_rx(8'h0F, 1'b0, 1'b0, 1'b0, 1);
        chk(rx_valid && rx_frame_err, "R7 framing error", {rx_valid, rx_frame_err}, 3);
        do_read();
        send_rx(8'hF0, 1'b0, 1'b0, 1'b1, 1);
        chk(rx_valid && !rx_frame_err && rx_data == 8'hF0, "R7 good stop",
            {rx_frame_err, rx_data}, {1'b0, 8'hF0});
        do_read();
    endtask

    task automatic t_glitch();
        @(negedge clk) rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        repeat (300) @(negedge clk);
        chk(rx_valid == 1'b0, "R8 glitch rejected", rx_valid, 0);
    endtask

    task automatic t_overrun();
        cfg_mode = 2'b00;
        send_rx(8'h01, 1'b0, 1'b0, 1'b1, 1);
        chk(rx_overrun == 1'b0, "R9 no overrun yet", rx_overrun, 0);
        send_rx(8'h02, 1'b0, 1'b0, 1'b1, 1);
        chk(rx_overrun && rx_data == 8'h02, "R9 overrun set", {rx_overrun, rx_data}, {1'b1, 8'h02});
        do_read();
        chk(!rx_overrun && !rx_valid, "R9 read clears overrun", {rx_overrun, rx_valid}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; divisor = 16'd1; cfg_mode = 2'b00;
        cfg_tx_wake = 1'b0; cfg_rx_wake = 1'b0; cfg_od_en = 1'b0;
        tx_data = 8'h00; tx_start = 1'b0; rxd = 1'b1; rx_read = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_formats();
        t_tx_div2();
        t_tx_od();
        t_rx_normal();
        t_rx_mc();
        t_rx_filter();
        t_ferr();
        t_glitch();
        t_overrun();
        finished = 1;
        summary();
    end
endmodule